// File: doc/BRIEF.md
# Five-Channel Reloadable Down-Counting Timer

This block is a timer peripheral with five independent down-counters behind a plain register bus: a byte address, 32-bit write data with a one-cycle write strobe, and combinational read data. Each channel's counting rate is set by two things. The first is an 8-bit prescaler, which it shares with the other channels of its group. The second is a power-of-two divider that belongs to the channel alone. The divided rate is a one-cycle enable on the system clock, so the block has no second clock domain.

Software places a reload value in a channel's count buffer and pulses the manual-update bit, which copies that value into the live counter. It then sets start, with or without auto-reload. Each time a counter passes zero, the channel's status flag is set. A status flag and its enable bit together drive a level interrupt line. Software clears the flag by writing one to it. The counter width is a parameter, either 16 or 32 bits, and the divider encoding shifts by one step between the two widths.

Top module: `mtimer5`

## Requirements
- R1: After reset, every readable offset returns zero and all interrupt lines are low.
- R2: Register offsets are fixed and all registers are 32 bits wide.
  - Prescalers at 0x00, 16 bits.
  - Divider selects at 0x04, 20 bits.
  - Control at 0x08.
  - Interrupt register at 0x44.
  - Channel c has its count buffer at 0x0C+12c.
  - Channels 0 to 3 have a compare buffer at 0x10+12c, which is stored and read back. Channel 4 has none.
  - The live counts are read-only: channels 0 to 3 at 0x14+12c, channel 4 at 0x40.
  - Any other offset reads zero, and a write to it changes nothing.
- R3: In the control register, channel c uses the 4-bit group at 4·g, where g is 0 for channel 0 and c+1 for the other channels. Within a group, bit 0 is start, bit 1 is manual update, bit 2 is a stored spare and bit 3 is auto-reload. Channel 4 is the exception: its auto-reload bit is bit 22. Bits 7:4 and bits 31:23 always read zero.
- R4: While a channel's manual-update bit is set, its live counter equals its count buffer from one cycle later, and the channel does not count.
- R5: A running channel ticks once every P cycles, where P = (prescale+1)·2^min(sel+base,4).
  - The prescale comes from bits 7:0 for channels 0 and 1, and from bits 15:8 for channels 2 to 4.
  - sel is the channel's 4-bit field at bit 4c of offset 0x04.
  - base is 1 when the width is 16 and 0 when it is 32.
  - The first tick arrives P cycles after the channel starts running.
  - Any write to 0x00 or 0x04 restarts the tick phase.
- R6: Each tick decrements the counter. A tick taken at zero is an expiry. With auto-reload set, an expiry reloads the count buffer, so a reload value of N gives (N+1)·P cycles between expiries.
- R7: With auto-reload clear, an expiry stops the channel with its counter at zero. It stays stopped until the next manual update.
- R8: While start is clear, the live count holds its value.
- R9: An expiry sets bit 5+c of 0x44. Writing one to that bit clears it.
- R10: Bits 4:0 of 0x44 are interrupt enables. irq[c] is high exactly while status bit c and enable bit c are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | One-cycle write strobe |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 5 | Level interrupt per channel |

## Verification
The hardest state to reach from the ports is several channels expiring repeatedly at unrelated rates. This has to happen while software clears status in the same cycles and the channels share a prescaler, because that is where phase, reload and clear-versus-set timing interact. The bench starts all five channels together with different reload values, dividers and group prescalers, including a divider select above the clamp. It then clears each interrupt in the cycle it is seen and measures the spacing between successive expiries. A behavioural reference model runs beside the design and is compared every clock, so any off-by-one in phase or reload timing shows up at once.

// File: rtl/mtimer5.sv
module mtimer5 #(
  parameter int CW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  input  logic        wr_en,
  output logic [31:0] rdata,
  output logic [4:0]  irq
);
  localparam int NCH   = 5;
  localparam int DBASE = (CW == 16) ? 1 : 0;
  localparam logic [22:0] CTRL_MASK = 23'h7FFF0F;

  logic [15:0] cfg0_q;
  logic [19:0] cfg1_q;
  logic [22:0] ctrl_q;
  logic [4:0]  en_q, stat_q, expd;
  logic [NCH-1:0][CW-1:0] cbuf_q, cnt_q;
  logic [3:0][CW-1:0]     cmp_q;
  logic [NCH-1:0] halt_q, st_go, st_man, st_ar;

  wire cfg_wr  = wr_en && (addr == 8'h00 || addr == 8'h04);
  wire int_wr  = wr_en && (addr == 8'h44);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg0_q <= '0;
      cfg1_q <= '0;
      ctrl_q <= '0;
      en_q   <= '0;
      stat_q <= '0;
    end else begin
      if (wr_en && addr == 8'h00) cfg0_q <= wdata[15:0];
      if (wr_en && addr == 8'h04) cfg1_q <= wdata[19:0];
      if (wr_en && addr == 8'h08) ctrl_q <= wdata[22:0] & CTRL_MASK;
      if (int_wr) en_q <= wdata[4:0];
      stat_q <= (stat_q & ~(int_wr ? wdata[9:5] : 5'd0)) | expd;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int GI  = (c == 0) ? 0 : c + 1;
    localparam int ARB = (c == 4) ? 4 * GI + 2 : 4 * GI + 3;
    localparam logic [7:0] OFS_CNT = 8'(12 + 12 * c);

    logic [7:0]  pre;
    logic [3:0]  sel;
    logic [4:0]  eraw;
    logic [2:0]  ex;
    logic [12:0] per, ph_q;
    logic        run, tick;

    assign st_go[c]  = ctrl_q[4*GI];
    assign st_man[c] = ctrl_q[4*GI+1];
    assign st_ar[c]  = ctrl_q[ARB];
    assign pre  = (c < 2) ? cfg0_q[7:0] : cfg0_q[15:8];
    assign sel  = cfg1_q[4*c +: 4];
    assign eraw = {1'b0, sel} + 5'(DBASE);
    assign ex   = (eraw > 5'd4) ? 3'd4 : eraw[2:0];
    assign per  = (13'(pre) + 13'd1) << ex;
    assign run  = st_go[c] && !st_man[c] && !halt_q[c];
    assign tick = run && !cfg_wr && (ph_q == per - 13'd1);
    assign expd[c] = tick && (cnt_q[c] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ph_q      <= '0;
        cnt_q[c]  <= '0;
        cbuf_q[c] <= '0;
        halt_q[c] <= 1'b0;
      end else begin
        if (cfg_wr || !run || tick) ph_q <= '0;
        else                        ph_q <= ph_q + 13'd1;
        if (wr_en && addr == OFS_CNT) cbuf_q[c] <= wdata[CW-1:0];
        if (st_man[c]) begin
          cnt_q[c]  <= cbuf_q[c];
          halt_q[c] <= 1'b0;
        end else if (tick) begin
          if (cnt_q[c] != '0)  cnt_q[c]  <= cnt_q[c] - 1'b1;
          else if (st_ar[c])   cnt_q[c]  <= cbuf_q[c];
          else                 halt_q[c] <= 1'b1;
        end
      end
    end

    if (c < 4) begin : g_cmp
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmp_q[c] <= '0;
        else if (wr_en && addr == OFS_CNT + 8'd4) cmp_q[c] <= wdata[CW-1:0];
      end
    end
  end

  assign irq = stat_q & en_q;

  always_comb begin
    rdata = '0;
    case (addr)
      8'h00: rdata = {16'd0, cfg0_q};
      8'h04: rdata = {12'd0, cfg1_q};
      8'h08: rdata = {9'd0, ctrl_q};
      8'h44: rdata = {22'd0, stat_q, en_q};
      8'h3C: rdata = 32'(cbuf_q[4]);
      8'h40: rdata = 32'(cnt_q[4]);
      default: ;
    endcase
    for (int c = 0; c < 4; c++) begin
      if (addr == 8'(12 + 12 * c)) rdata = 32'(cbuf_q[c]);
      if (addr == 8'(16 + 12 * c)) rdata = 32'(cmp_q[c]);
      if (addr == 8'(20 + 12 * c)) rdata = 32'(cnt_q[c]);
    end
  end
endmodule

// File: rtl/mtimer5_chk.sv
module mtimer5_chk #(
  parameter int CW = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [4:0][CW-1:0]  cnt,
  input logic [4:0][CW-1:0]  cbuf,
  input logic [4:0]          go,
  input logic [4:0]          man,
  input logic [4:0]          stat
);
  for (genvar c = 0; c < 5; c++) begin : g_a
    AST_MANUAL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      man[c] |=> cnt[c] == $past(cbuf[c])); // R4
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!go[c] && !man[c]) |=> $stable(cnt[c])); // R8
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!man[c] && cnt[c] != '0) |=> (cnt[c] == $past(cnt[c]) || cnt[c] == $past(cnt[c]) - 1'b1)); // R6
    AST_STATUS_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[c]) |-> $past(cnt[c]) == '0); // R9
  end
endmodule

bind mtimer5 mtimer5_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .cbuf(cbuf_q),
  .go(st_go), .man(st_man), .stat(stat_q)
);

// File: tb/mtimer5_bench.sv
`timescale 1ns/1ps
module mtimer5_bench;
  localparam int CW = 16;
  localparam int BASE = 1;
  localparam logic [31:0] VMASK = (CW == 32) ? 32'hFFFFFFFF : ((32'd1 << CW) - 32'd1);

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [4:0] irq;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mtimer5 #(.CW(CW)) u_mtimer5 (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rdata(rdata), .irq(irq));

  // reference model
  logic [31:0] m_cfg0, m_cfg1, m_ctrl, m_en, m_st;
  logic [31:0] m_cbuf[5], m_cmp[5], m_cnt[5];
  int m_ph[5];
  bit m_halt[5];

  function automatic int gidx(int c); return (c == 0) ? 0 : c + 1; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg0 = 0; m_cfg1 = 0; m_ctrl = 0; m_en = 0; m_st = 0;
      for (int c = 0; c < 5; c++) begin
        m_cbuf[c] = 0; m_cmp[c] = 0; m_cnt[c] = 0; m_ph[c] = 0; m_halt[c] = 0;
      end
    end else begin
      automatic bit cfgw = wr_en && (addr == 8'h00 || addr == 8'h04);
      automatic logic [31:0] setv = 0;
      cyc++;
      for (int c = 0; c < 5; c++) begin
        automatic int g = gidx(c);
        automatic bit go = m_ctrl[4*g];
        automatic bit mn = m_ctrl[4*g+1];
        automatic bit ar = (c == 4) ? m_ctrl[22] : m_ctrl[4*g+3];
        automatic int pre = (c < 2) ? int'(m_cfg0[7:0]) : int'(m_cfg0[15:8]);
        automatic int e = int'(m_cfg1[4*c +: 4]) + BASE;
        automatic int p;
        automatic bit run = go && !mn && !m_halt[c];
        automatic bit tk = 0;
        if (e > 4) e = 4;
        p = (pre + 1) * (1 << e);
        if (cfgw || !run) m_ph[c] = 0;
        else if (m_ph[c] == p - 1) begin m_ph[c] = 0; tk = 1; end
        else m_ph[c]++;
        if (mn) begin m_cnt[c] = m_cbuf[c]; m_halt[c] = 0; end
        else if (tk) begin
          if (m_cnt[c] != 0) m_cnt[c] = m_cnt[c] - 1;
          else begin
            setv[c] = 1;
            if (ar) m_cnt[c] = m_cbuf[c]; else m_halt[c] = 1;
          end
        end
      end
      if (wr_en && addr == 8'h44) m_st = m_st & ~{27'd0, wdata[9:5]};
      m_st = m_st | setv;
      if (wr_en) begin
        if (addr == 8'h00) m_cfg0 = wdata & 32'hFFFF;
        if (addr == 8'h04) m_cfg1 = wdata & 32'hFFFFF;
        if (addr == 8'h08) m_ctrl = wdata & 32'h007FFF0F;
        if (addr == 8'h44) m_en = wdata & 32'h1F;
        for (int c = 0; c < 5; c++) begin
          if (addr == 8'(12 + 12*c)) m_cbuf[c] = wdata & VMASK;
          if (c < 4 && addr == 8'(16 + 12*c)) m_cmp[c] = wdata & VMASK;
        end
      end
    end
  end

  function automatic logic [31:0] m_rd(logic [7:0] a);
    if (a == 8'h00) return m_cfg0;
    if (a == 8'h04) return m_cfg1;
    if (a == 8'h08) return m_ctrl;
    if (a == 8'h44) return (m_st << 5) | m_en;
    if (a == 8'h40) return m_cnt[4];
    for (int c = 0; c < 5; c++) begin
      if (a == 8'(12 + 12*c)) return m_cbuf[c];
      if (c < 4 && a == 8'(16 + 12*c)) return m_cmp[c];
      if (c < 4 && a == 8'(20 + 12*c)) return m_cnt[c];
    end
    return 0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // R10: interrupt lines against the model on every clock
  always @(negedge clk) if (rst_n && !done) chk("R10 irq", {27'd0, irq}, (m_st & m_en) & 32'h1F);

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(string tag, logic [7:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
    chk(tag, v, m_rd(a));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  int last[5], per[5], nrise[5];
  logic [4:0] hi;

  task automatic run_clear(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int c = 0; c < 5; c++) if (irq[c] && !hi[c]) begin
        if (last[c] >= 0) per[c] = cyc - last[c];
        last[c] = cyc; nrise[c]++;
      end
      hi = irq;
      if (irq != 0) begin addr = 8'h44; wdata = {22'd0, irq, 5'h1F}; wr_en = 1'b1; end
      else wr_en = 1'b0;
    end
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    logic [31:0] v, a0, b0;
    for (int c = 0; c < 5; c++) begin last[c] = -1; per[c] = 0; nrise[c] = 0; end
    hi = 0;
    idle(3); rst_n = 1'b1; idle(1);
    // R1 reset state
    for (int a = 0; a < 76; a += 4) begin
      rd("R1 reset", 8'(a), v); chk("R1 reset literal", v, 0);
    end
    chk("R1 irq", {27'd0, irq}, 0);
    // R2 register map
    wr(8'h00, 32'hFFFF_0100); rd("R2 cfg0", 8'h00, v); chk("R2 cfg0 lit", v, 32'h0100);
    wr(8'h04, 32'hFFF7_0010); rd("R2 cfg1", 8'h04, v); chk("R2 cfg1 lit", v, 32'h7_0010);
    wr(8'h0C, 3); wr(8'h18, 2); wr(8'h24, 5); wr(8'h30, 1); wr(8'h3C, 2);
    wr(8'h10, 32'h11); wr(8'h1C, 32'h22); wr(8'h28, 32'h33); wr(8'h34, 32'h44);
    wr(8'h40, 32'h99);
    for (int a = 12; a < 68; a += 4) rd("R2 map", 8'(a), v);
    rd("R2 ch4 live", 8'h40, v); chk("R2 live ro", v, 0);
    rd("R2 cmp3", 8'h34, v); chk("R2 cmp3 lit", v, 32'h44);
    // R3 control mask
    wr(8'h08, 32'hFFFF_FFFF); rd("R3 mask", 8'h08, v); chk("R3 mask lit", v, 32'h007F_FF0F);
    // R4 manual update on all channels
    wr(8'h08, 32'h0022_2202); idle(1);
    rd("R4 ch0", 8'h14, v); chk("R4 ch0 lit", v, 3);
    rd("R4 ch4", 8'h40, v); chk("R4 ch4 lit", v, 2);
    // R5 R6 R7: start, ch1 one-shot, others auto-reload (ch4 via bit 22)
    wr(8'h44, 32'h1F);
    wr(8'h08, 32'h0059_9109);
    run_clear(400);
    chk("R6 ch0 period", per[0], 8);
    chk("R5 ch2 shared prescale period", per[2], 24);
    chk("R5 ch3 period", per[3], 8);
    chk("R3 ch4 auto-reload bit22 period", per[4], 96);
    chk("R5 ch4 second expiry", nrise[4] >= 2, 1);
    chk("R7 ch1 single expiry", nrise[1], 1);
    rd("R7 ch1 count", 8'h20, v); chk("R7 ch1 zero", v, 0);
    // R9 R10 disable and clear, status still sets
    wr(8'h44, 32'h3E0); idle(20);
    rd("R9 status", 8'h44, v); chk("R9 ch0 status set", v[5], 1);
    chk("R10 masked", {27'd0, irq}, 0);
    wr(8'h44, 32'h3E0); rd("R9 cleared", 8'h44, v);
    // R8 stop ch0
    wr(8'h08, 32'h0059_9108); idle(2);
    rd("R8 a", 8'h14, a0); idle(12); rd("R8 b", 8'h14, b0);
    chk("R8 frozen", b0, a0);
    // R5 phase restart by config write, then compare
    wr(8'h00, 32'h0300); idle(30); rd("R5 ch3 live", 8'h38, v);
    // R4 manual with start set holds buffer
    wr(8'h08, 32'h0059_910B); idle(10);
    rd("R4 hold", 8'h14, v); chk("R4 hold lit", v, 3);
    // R2 unused and read-only offsets
    wr(8'h48, 32'hFFFF_FFFF); rd("R2 unused", 8'h48, v); chk("R2 unused lit", v, 0);
    wr(8'h14, 32'h55); rd("R2 live ro ch0", 8'h14, v); chk("R2 live ro lit", v, 3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: R6 run did not complete, actual hung expected done");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule